// File: doc/BRIEF.md
# Microcoded Control Sequencer with Arithmetic Unit

This block is a control sequencer whose state is an 8-bit step counter. The counter addresses a constant microprogram held inside the design. Each 24-bit microword chooses three things: the condition that lets the step execute, the condition that makes the counter jump instead of increment, and the jump destination. It also drives a small arithmetic unit that works on an accumulator and on operands taken from a 16-word internal scratch memory or from an immediate value. The unit's condition flags are latched in a flag register, and later microwords branch on them, so the step order can depend on computed results as well as on four external condition pins.

One microword bit requests a scratch-memory write of the arithmetic result. The write is registered and lands one clock after its microinstruction. An operand read of the address being written in that cycle returns the new value. The state counter, accumulator, flags and the write pulse with its address and data are visible at the ports. All pins are plain level signals with no handshake: external conditions are sampled on every rising clock edge.

The microprogram is computed by a function in the package. It loads, adds, increments into signed overflow, stores and re-reads memory, compares, and takes each kind of branch. It waits on two pins and branches on two others, and it ends in a hold step.

Top module: `mcode_engine`

## Requirements
- R1: While the active-low reset `rst_n` is low, the step counter, accumulator, flags, all 16 scratch words and the write pulse are zero.
- R2: The microword at the counter's address is decoded with the most significant bit first: branch select [23:21], enable select [20:19], target [18:11], operation [10:7], operand/destination select [6:5], write request [4], memory address [3:0].
- R3: The enable select picks when a step executes: 0 always, 1 never (hold), 2 when `ext_cond[0]` is 1, 3 when `ext_cond[1]` is 1. A step that does not execute leaves the counter, accumulator, flags and memory unchanged and issues no write.
- R4: An executing step whose branch condition is true loads the target into the counter, and otherwise adds one to the counter, wrapping from 255 to 0. Branch select codes: 0 never, 1 always, 2 Z, 3 C, 4 N, 5 V, 6 `ext_cond[2]`, 7 `ext_cond[3]`.
- R5: Branch conditions on flags use the flag register as it stood before the current microinstruction, not that microinstruction's own result.
- R6: Operation codes (A is the accumulator, B the selected operand): 0 no-op (result A), 1 A+B, 2 A-B, 3 A AND B, 4 A OR B, 5 A XOR B, 6 B, 7 A+1; codes 8 to 15 act as code 0.
- R7: Flags are `flags_o` = {V,N,C,Z} (bit 3 to bit 0). Every code except the no-op class replaces them when its step executes: Z when the whole 8-bit result is zero, N the result MSB, C the carry out for codes 1 and 7 and "no borrow" (A >= B unsigned) for code 2, V the signed overflow for codes 1, 2 and 7, and C and V are 0 for codes 3 to 6.
- R8: Select bit 1 chooses B: 1 is the zero-extended target field, 0 is scratch word [memory address]. Select bit 0 set writes the result to the accumulator.
- R9: A write request on an executing step raises `wr_pulse_o` for exactly the next cycle, with `wr_addr_o` equal to the memory address and `wr_data_o` equal to the result. The word is updated at the end of that cycle.
- R10: An operand read of the address whose write is pending in the same cycle returns the pending data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_cond | input | 4 | External conditions: bits 0 and 1 gate execution, bits 2 and 3 gate branches |
| pc_o | output | 8 | Step counter |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 4 | Flag register {V,N,C,Z} |
| wr_pulse_o | output | 1 | One-cycle scratch-memory write strobe |
| wr_addr_o | output | 4 | Address of the write in progress |
| wr_data_o | output | 8 | Data of the write in progress |

## Verification
Two functions can fall in the same cycle: the commit of a registered memory write, and the operand read of that same word by the next microinstruction. The microprogram stores the accumulator in one step and, in the very next step, subtracts that same word in a compare whose zero flag is then branched on. A missing bypass therefore shows up in the flags, in the branch target taken and in every later accumulator value. A cycle model in the bench runs the same microwords under all sixteen constant condition patterns and under random ones. It judges the counter, accumulator, flags and write strobe after every edge.

// File: rtl/mcode_pkg.sv
package mcode_pkg;
  localparam int PC_W   = 8;
  localparam int DATA_W = 8;
  localparam int RAM_AW = 4;
  localparam int EXT_W  = 4;

  // enable select
  localparam logic [1:0] EN_RUN  = 2'd0;
  localparam logic [1:0] EN_HOLD = 2'd1;
  localparam logic [1:0] EN_X0   = 2'd2;
  localparam logic [1:0] EN_X1   = 2'd3;

  // branch select
  localparam logic [2:0] BR_NEVER  = 3'd0;
  localparam logic [2:0] BR_ALWAYS = 3'd1;
  localparam logic [2:0] BR_Z      = 3'd2;
  localparam logic [2:0] BR_C      = 3'd3;
  localparam logic [2:0] BR_N      = 3'd4;
  localparam logic [2:0] BR_V      = 3'd5;
  localparam logic [2:0] BR_X2     = 3'd6;
  localparam logic [2:0] BR_X3     = 3'd7;

  // arithmetic operations
  localparam logic [3:0] OP_NOP  = 4'd0;
  localparam logic [3:0] OP_ADD  = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_AND  = 4'd3;
  localparam logic [3:0] OP_OR   = 4'd4;
  localparam logic [3:0] OP_XOR  = 4'd5;
  localparam logic [3:0] OP_LOAD = 4'd6;
  localparam logic [3:0] OP_INC  = 4'd7;

  // operand / destination select: bit1 immediate operand, bit0 accumulator write
  localparam logic [1:0] DS_MEM      = 2'd0;
  localparam logic [1:0] DS_MEM_ACC  = 2'd1;
  localparam logic [1:0] DS_IMM      = 2'd2;
  localparam logic [1:0] DS_IMM_ACC  = 2'd3;

  typedef struct packed {
    logic [2:0]        bsel;
    logic [1:0]        esel;
    logic [PC_W-1:0]   tgt;
    logic [3:0]        op;
    logic [1:0]        dsel;
    logic              wr;
    logic [RAM_AW-1:0] ra;
  } uword_t;

  function automatic uword_t mk(input logic [2:0] b, input logic [1:0] e,
                                input logic [PC_W-1:0] t, input logic [3:0] o,
                                input logic [1:0] d, input logic w,
                                input logic [RAM_AW-1:0] a);
    uword_t u;
    u.bsel = b; u.esel = e; u.tgt = t; u.op = o; u.dsel = d; u.wr = w; u.ra = a;
    return u;
  endfunction

  // constant microprogram
  function automatic uword_t ucode_word(input logic [PC_W-1:0] addr);
    case (addr)
      8'd0:  return mk(BR_NEVER,  EN_RUN,  8'h00, OP_LOAD, DS_IMM_ACC, 1'b0, 4'd0);
      8'd1:  return mk(BR_NEVER,  EN_X0,   8'h00, OP_NOP,  DS_MEM,     1'b0, 4'd0);
      8'd2:  return mk(BR_NEVER,  EN_RUN,  8'h7F, OP_ADD,  DS_IMM_ACC, 1'b0, 4'd0);
      8'd3:  return mk(BR_NEVER,  EN_RUN,  8'h00, OP_INC,  DS_MEM_ACC, 1'b0, 4'd0);
      8'd4:  return mk(BR_V,      EN_RUN,  8'd6,  OP_NOP,  DS_MEM,     1'b0, 4'd0);
      8'd5:  return mk(BR_NEVER,  EN_RUN,  8'hEE, OP_LOAD, DS_IMM_ACC, 1'b0, 4'd0);
      8'd6:  return mk(BR_NEVER,  EN_RUN,  8'h00, OP_NOP,  DS_MEM,     1'b1, 4'd3);
      8'd7:  return mk(BR_NEVER,  EN_RUN,  8'h00, OP_SUB,  DS_MEM,     1'b0, 4'd3);
      8'd8:  return mk(BR_Z,      EN_RUN,  8'd10, OP_NOP,  DS_MEM,     1'b0, 4'd0);
      8'd9:  return mk(BR_NEVER,  EN_RUN,  8'hEE, OP_LOAD, DS_IMM_ACC, 1'b0, 4'd0);
      8'd10: return mk(BR_X2,     EN_RUN,  8'd13, OP_OR,   DS_IMM_ACC, 1'b0, 4'd0);
      8'd11: return mk(BR_NEVER,  EN_RUN,  8'h05, OP_ADD,  DS_IMM_ACC, 1'b0, 4'd0);
      8'd12: return mk(BR_ALWAYS, EN_RUN,  8'd14, OP_AND,  DS_IMM_ACC, 1'b0, 4'd0);
      8'd13: return mk(BR_NEVER,  EN_X1,   8'h00, OP_ADD,  DS_MEM_ACC, 1'b0, 4'd3);
      8'd14: return mk(BR_NEVER,  EN_RUN,  8'h3C, OP_AND,  DS_IMM_ACC, 1'b0, 4'd0);
      8'd15: return mk(BR_NEVER,  EN_RUN,  8'h00, OP_XOR,  DS_MEM_ACC, 1'b1, 4'd5);
      8'd16: return mk(BR_NEVER,  EN_RUN,  8'h90, OP_SUB,  DS_IMM_ACC, 1'b0, 4'd0);
      8'd17: return mk(BR_C,      EN_RUN,  8'd19, OP_NOP,  DS_MEM,     1'b0, 4'd0);
      8'd18: return mk(BR_NEVER,  EN_RUN,  8'h40, OP_OR,   DS_IMM_ACC, 1'b0, 4'd0);
      8'd19: return mk(BR_N,      EN_RUN,  8'd21, OP_NOP,  DS_MEM,     1'b0, 4'd0);
      8'd20: return mk(BR_NEVER,  EN_RUN,  8'h00, OP_ADD,  DS_MEM_ACC, 1'b0, 4'd5);
      8'd21: return mk(BR_X3,     EN_RUN,  8'd2,  OP_INC,  DS_MEM_ACC, 1'b0, 4'd0);
      8'd22: return mk(BR_NEVER,  EN_HOLD, 8'h00, OP_NOP,  DS_MEM,     1'b0, 4'd0);
      default: return mk(BR_ALWAYS, EN_RUN, 8'd0, OP_NOP,  DS_MEM,     1'b0, 4'd0);
    endcase
  endfunction
endpackage

// File: rtl/mc_rom.sv
module mc_rom
  import mcode_pkg::*;
#(
  parameter int AW = PC_W
) (
  input  logic [AW-1:0] addr,
  output uword_t        word
);
  assign word = ucode_word(PC_W'(addr));
endmodule

// File: rtl/mc_seq.sv
module mc_seq #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    ext,
  input  logic [3:0]    flags,
  input  logic [2:0]    bsel,
  input  logic [1:0]    esel,
  input  logic [PW-1:0] tgt,
  output logic [PW-1:0] pc,
  output logic          adv
);
  localparam int N_EN = 4;
  localparam int N_BR = 8;

  logic [N_EN-1:0] en_src;
  logic [N_BR-1:0] br_src;
  logic            take;
  logic [PW-1:0]   pc_q;

  assign en_src = {ext[1], ext[0], 1'b0, 1'b1};
  assign br_src = {ext[3], ext[2], flags[3], flags[2], flags[1], flags[0], 1'b1, 1'b0};
  assign adv    = en_src[esel];
  assign take   = br_src[bsel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc_q <= '0;
    else if (adv)  pc_q <= take ? tgt : pc_q + 1'b1;
  end

  assign pc = pc_q;

  // R3
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(pc_q));
  // R4
  branch_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && take) |=> pc_q == $past(tgt));
  // R4
  seq_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !take) |=> pc_q == PW'($past(pc_q) + 1'b1));
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mcode_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res,
  output logic [3:0]    flg,
  output logic          upd
);
  localparam int MSB = DW - 1;

  logic [DW:0] sum;
  logic        cy;
  logic        ov;

  always_comb begin
    sum = '0;
    cy  = 1'b0;
    ov  = 1'b0;
    upd = 1'b1;
    res = a;
    case (op)
      OP_ADD: begin
        sum = {1'b0, a} + {1'b0, b};
        res = sum[MSB:0];
        cy  = sum[DW];
        ov  = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
      end
      OP_SUB: begin
        sum = {1'b0, a} - {1'b0, b};
        res = sum[MSB:0];
        cy  = ~sum[DW];
        ov  = (a[MSB] != b[MSB]) && (res[MSB] != a[MSB]);
      end
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_LOAD: res = b;
      OP_INC: begin
        sum = {1'b0, a} + (DW+1)'(1);
        res = sum[MSB:0];
        cy  = sum[DW];
        ov  = ~a[MSB] & res[MSB];
      end
      default: upd = 1'b0;
    endcase
    flg = {ov, res[MSB], cy, (res == '0)};
  end
endmodule

// File: rtl/mc_dpath.sv
module mc_dpath #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec,
  input  logic [1:0]    dsel,
  input  logic          wr_en,
  input  logic [AW-1:0] ra,
  input  logic [DW-1:0] imm,
  input  logic [DW-1:0] res,
  input  logic [3:0]    nflags,
  input  logic          upd,
  output logic [DW-1:0] acc,
  output logic [DW-1:0] opb,
  output logic [3:0]    flags,
  output logic          wr_pulse,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] acc_q;
  logic [3:0]    flags_q;
  logic          wr_q;
  logic [AW-1:0] wa_q;
  logic [DW-1:0] wd_q;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_word
      logic [DW-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          word_q <= '0;
        else if (wr_q && wa_q == AW'(gi))    word_q <= wd_q;
      end
      assign mem[gi] = word_q;
    end
  endgenerate

  // bypass of the write committing this cycle
  assign rd  = (wr_q && wa_q == ra) ? wd_q : mem[ra];
  assign opb = dsel[1] ? imm : rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      flags_q <= '0;
      wr_q    <= 1'b0;
      wa_q    <= '0;
      wd_q    <= '0;
    end else begin
      wr_q <= exec & wr_en;
      wa_q <= ra;
      wd_q <= res;
      if (exec && upd)     flags_q <= nflags;
      if (exec && dsel[0]) acc_q   <= res;
    end
  end

  assign acc      = acc_q;
  assign flags    = flags_q;
  assign wr_pulse = wr_q;
  assign wr_addr  = wa_q;
  assign wr_data  = wd_q;

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec || !upd) |=> $stable(flags_q));
  // R7
  zero_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && upd) |=> flags_q[0] == ($past(res) == '0));
  // R9
  write_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> mem[$past(wa_q)] == $past(wd_q));
  // R3
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> !wr_q && $stable(acc_q));
endmodule

// File: rtl/mcode_engine.sv
module mcode_engine
  import mcode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EXT_W-1:0]  ext_cond,
  output logic [PC_W-1:0]   pc_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [3:0]        flags_o,
  output logic              wr_pulse_o,
  output logic [RAM_AW-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  uword_t            uw;
  logic [PC_W-1:0]   pc;
  logic              adv;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] res;
  logic [3:0]        flags;
  logic [3:0]        nflags;
  logic              upd;

  mc_rom #(.AW(PC_W)) u_rom (
    .addr (pc),
    .word (uw)
  );

  mc_seq #(.PW(PC_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .ext   (ext_cond),
    .flags (flags),
    .bsel  (uw.bsel),
    .esel  (uw.esel),
    .tgt   (uw.tgt),
    .pc    (pc),
    .adv   (adv)
  );

  mc_alu #(.DW(DATA_W)) u_alu (
    .op  (uw.op),
    .a   (acc),
    .b   (opb),
    .res (res),
    .flg (nflags),
    .upd (upd)
  );

  mc_dpath #(.DW(DATA_W), .AW(RAM_AW)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .exec     (adv),
    .dsel     (uw.dsel),
    .wr_en    (uw.wr),
    .ra       (uw.ra),
    .imm      (DATA_W'(uw.tgt)),
    .res      (res),
    .nflags   (nflags),
    .upd      (upd),
    .acc      (acc),
    .opb      (opb),
    .flags    (flags),
    .wr_pulse (wr_pulse_o),
    .wr_addr  (wr_addr_o),
    .wr_data  (wr_data_o)
  );

  assign pc_o    = pc;
  assign acc_o   = acc;
  assign flags_o = flags;

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |-> pc == '0 && !wr_pulse_o);
endmodule

// File: tb/mcode_engine_test.sv
`timescale 1ns/1ps
module mcode_engine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ext = 4'd0;
  logic [7:0] pc_o, acc_o, wr_data_o;
  logic [3:0] flags_o, wr_addr_o;
  logic       wr_pulse_o;

  int n_chk = 0;
  int n_fail = 0;
  int halts = 0;
  bit done = 1'b0;

  // model state
  logic [7:0] m_pc, m_acc, m_wd;
  logic [3:0] m_fl, m_wa;
  logic       m_wq;
  logic [7:0] m_ram [16];

  always #2 clk = ~clk;

  mcode_engine uut (
    .clk(clk), .rst_n(rst_n), .ext_cond(ext),
    .pc_o(pc_o), .acc_o(acc_o), .flags_o(flags_o),
    .wr_pulse_o(wr_pulse_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pc = 8'd0; m_acc = 8'd0; m_fl = 4'd0; m_wq = 1'b0; m_wa = 4'd0; m_wd = 8'd0;
    for (int i = 0; i < 16; i++) m_ram[i] = 8'd0;
  endtask

  // one clock of the specified behaviour (R2..R10)
  task automatic model_step(input logic [3:0] x);
    logic [23:0] w;
    logic [2:0] bs; logic [1:0] es, ds; logic [7:0] tg, rd, b, r;
    logic [3:0] op, ra, nf; logic we, go, tk, c, v, up;
    int ia, ib, sa, sb, s, sv;
    w  = mcode_pkg::ucode_word(m_pc);
    bs = w[23:21]; es = w[20:19]; tg = w[18:11]; op = w[10:7];
    ds = w[6:5];   we = w[4];     ra = w[3:0];
    case (es)
      2'd0: go = 1'b1;
      2'd1: go = 1'b0;
      2'd2: go = x[0];
      default: go = x[1];
    endcase
    case (bs)
      3'd0: tk = 1'b0;
      3'd1: tk = 1'b1;
      3'd2: tk = m_fl[0];
      3'd3: tk = m_fl[1];
      3'd4: tk = m_fl[2];
      3'd5: tk = m_fl[3];
      3'd6: tk = x[2];
      default: tk = x[3];
    endcase
    rd = (m_wq && m_wa == ra) ? m_wd : m_ram[ra];
    b  = ds[1] ? tg : rd;
    ia = int'(m_acc); ib = int'(b);
    sa = (ia > 127) ? ia - 256 : ia;
    sb = (ib > 127) ? ib - 256 : ib;
    c = 1'b0; v = 1'b0; up = 1'b1; r = m_acc;
    case (op)
      4'd1: begin s = ia + ib; r = s[7:0]; c = (s > 255); sv = sa + sb; v = (sv > 127) || (sv < -128); end
      4'd2: begin s = ia - ib; r = s[7:0]; c = (ia >= ib); sv = sa - sb; v = (sv > 127) || (sv < -128); end
      4'd3: r = m_acc & b;
      4'd4: r = m_acc | b;
      4'd5: r = m_acc ^ b;
      4'd6: r = b;
      4'd7: begin s = ia + 1; r = s[7:0]; c = (s > 255); v = (sa + 1 > 127); end
      default: up = 1'b0;
    endcase
    nf = {v, r[7], c, (r == 8'd0)};
    if (m_wq) m_ram[m_wa] = m_wd;
    m_wq = go && we; m_wa = ra; m_wd = r;
    if (go) begin
      if (up) m_fl = nf;
      if (ds[0]) m_acc = r;
      m_pc = tk ? tg : m_pc + 8'd1;
    end
  endtask

  task automatic compare_all();
    chk("R2 R3 R4 R5", "step counter", pc_o, m_pc);
    chk("R6 R8 R10", "accumulator", acc_o, m_acc);
    chk("R7", "flags", flags_o, m_fl);
    chk("R9", "write pulse", wr_pulse_o, m_wq);
    if (m_wq) begin
      chk("R9", "write address", wr_addr_o, m_wa);
      chk("R9", "write data", wr_data_o, m_wd);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ext = 4'd0;
    model_reset();
    @(negedge clk);
    chk("R1", "reset counter", pc_o, 8'd0);
    chk("R1", "reset accumulator", acc_o, 8'd0);
    chk("R1", "reset flags", flags_o, 4'd0);
    chk("R1", "reset write pulse", wr_pulse_o, 1'b0);
    rst_n = 1'b1;
  endtask

  initial begin
    for (int run = 0; run < 56; run++) begin
      apply_reset();
      for (int cyc = 0; cyc < 70; cyc++) begin
        logic [3:0] x;
        if (run < 16) x = 4'(run);
        else begin
          x = 4'($urandom);
          x[3] = (($urandom % 4) == 0);
        end
        ext = x;
        model_step(x);
        @(posedge clk);
        @(negedge clk);
        compare_all();
        if (m_pc == 8'd22 && pc_o == 8'd22) halts++;
      end
    end
    // R3: the hold step is reached and stays put
    chk("R3", "hold step reached", (halts > 0), 1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule